// File: doc/BRIEF.md
# DMA channel address sequencer

This block is the address and count engine of one peripheral DMA channel. Software sets a start source address, a start destination address and a start transfer size, then writes the channel enable. The block copies the start values into its current registers and becomes active. Each accepted data beat moves the two current addresses and takes one from the remaining count. Each side has its own address mode and direction. A linear side keeps stepping by the beat width. A circular side steps the same way but returns to its start address after a programmed number of beats. A fixed-address override freezes a circular side at its start address. A linear side is unaffected by that override.

When the remaining count runs out, the block raises a one-cycle done pulse. If auto-reload is on, the channel restarts from its start values and stays active. If auto-reload is off, the channel goes idle and keeps its final values.

Beats arrive on a valid/ready pair. `beat_ready` is high exactly while the channel is active. A beat is taken in a cycle where both `beat_valid` and `beat_ready` are high and no enable write occurs. While `beat_ready` is low, a valid beat stays pending upstream and does nothing here.

Top module: `dma_addr_seq`

## Requirements
- R1: After reset, `active`, `done`, `cur_cnt`, `cur_src` and `cur_dst` are all zero.
- R2: An enable write with `en_val`=1 loads `cur_src`, `cur_dst` and `cur_cnt` from the start values. The channel is active only if the start size is nonzero. While active, `cur_cnt` is never zero.
- R3: `beat_ready` equals `active`. A beat offered while inactive changes no output.
- R4: On a linear side (mode bit 0), each accepted beat moves the address by the width in bytes, modulo 2^ADDR_W. Width code 0 gives 1 byte, code 1 gives 2 bytes, and codes 2 and 3 give 4 bytes. The address moves up when the increment bit is 1 and down when it is 0.
- R5: A circular side (mode bit 1, fixed override 0) steps like R4. On the beat that completes `cfg_blk_len` beats since the last load or wrap, it returns to its start address. A block length of 0 behaves as 1.
- R6: With `cfg_fixed_en`=1, a circular side keeps its start address on every beat. A linear side still follows R4.
- R7: Each accepted beat lowers `cur_cnt` by one, except for the last beat.
- R8: `done` is high for one cycle, in the cycle after the beat that took `cur_cnt` from 1. This happens with or without reload.
- R9: With auto-reload off, the last beat leaves `cur_cnt` at 0 and `active` low. The addresses keep the values that beat gave them.
- R10: With auto-reload on, the last beat reloads both addresses and the count from the start values. `active` stays high when the start size is nonzero.
- R11: An enable write with `en_val`=0 clears `active` and keeps the addresses and the count. An enable write in the same cycle as a beat wins, and the beat is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_src_mode | input | 1 | Source mode: 0 linear, 1 circular |
| cfg_src_inc | input | 1 | Source direction: 1 up, 0 down |
| cfg_dst_mode | input | 1 | Destination mode: 0 linear, 1 circular |
| cfg_dst_inc | input | 1 | Destination direction: 1 up, 0 down |
| cfg_width | input | 2 | Beat width code (0: 1 byte, 1: 2 bytes, 2/3: 4 bytes) |
| cfg_fixed_en | input | 1 | Turns a circular side into a fixed address |
| cfg_auto_reload | input | 1 | Restart from the start values on completion |
| cfg_src_start | input | ADDR_W | Start source address |
| cfg_dst_start | input | ADDR_W | Start destination address |
| cfg_size | input | CNT_W | Start transfer size in beats |
| cfg_blk_len | input | BLK_W | Circular block length in beats |
| en_we | input | 1 | Channel-enable write strobe |
| en_val | input | 1 | Value written with `en_we` |
| beat_valid | input | 1 | A data beat is offered |
| beat_ready | output | 1 | Beat can be taken (channel active) |
| cur_src | output | ADDR_W | Current source address |
| cur_dst | output | ADDR_W | Current destination address |
| cur_cnt | output | CNT_W | Remaining beats |
| active | output | 1 | Channel active |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with ADDR_W=16, CNT_W=6 and BLK_W=3. With a 16-bit address, the downward steps wrap below zero early, so that wrap gets exercised. A 3-bit block length lets every value from 0 to 4 be swept. The sweep covers every width code, both modes and both directions on each side, and the fixed override on and off. The source and destination always take opposite modes and directions, so both sides are compared in every run. Auto-reload alternates between runs. The sweep also covers enabling with size zero, beats offered while idle, and an enable write in the same cycle as a beat.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  typedef enum logic {
    AM_LINEAR = 1'b0,
    AM_CIRC   = 1'b1
  } addr_mode_e;

  // byte span of one beat for a width code; codes 2 and 3 both mean a word
  function automatic logic [2:0] beat_bytes(input logic [1:0] code);
    case (code)
      2'd0:    beat_bytes = 3'd1;
      2'd1:    beat_bytes = 3'd2;
      default: beat_bytes = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/dma_addr_side.sv
module dma_addr_side
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              mode,
  input  logic              inc,
  input  logic              fixed_en,
  input  logic [1:0]        width,
  input  logic [ADDR_W-1:0] start,
  input  logic [BLK_W-1:0]  blk_len,
  output logic [ADDR_W-1:0] addr
);

  logic [BLK_W-1:0]  pos;
  logic [BLK_W:0]    pos_nx;
  logic [ADDR_W-1:0] delta;
  logic [ADDR_W-1:0] addr_lin;
  logic              is_circ;
  logic              is_fixed;
  logic              wrap;

  assign is_fixed = (addr_mode_e'(mode) == AM_CIRC) && fixed_en;
  assign is_circ  = (addr_mode_e'(mode) == AM_CIRC) && !fixed_en;
  assign delta    = ADDR_W'(beat_bytes(width));
  assign addr_lin = inc ? (addr + delta) : (addr - delta);
  assign pos_nx   = {1'b0, pos} + {{BLK_W{1'b0}}, 1'b1};
  // a zero block length compares as "already complete", i.e. acts as one
  assign wrap     = is_circ && (pos_nx >= {1'b0, blk_len});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      pos  <= '0;
    end else if (load) begin
      addr <= start;
      pos  <= '0;
    end else if (step) begin
      if (is_fixed) begin
        addr <= addr;
      end else if (wrap) begin
        addr <= start;
        pos  <= '0;
      end else begin
        addr <= addr_lin;
        if (is_circ) pos <= pos_nx[BLK_W-1:0];
      end
    end
  end

  // R6: fixed override pins a circular side
  p_fixed_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && mode && fixed_en) |=> $stable(addr));

  // R4: a linear side always moves on a beat
  p_lin_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !mode) |=> (addr != $past(addr)));

  // R5: a wrap lands on the start address
  p_wrap_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && wrap) |=> (addr == $past(start)));

endmodule

// File: rtl/dma_beat_count.sv
module dma_beat_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             en_val,
  input  logic             step,
  input  logic             auto_reload,
  input  logic [CNT_W-1:0] size,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             done,
  output logic             start_load,
  output logic             reload
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic last;
  logic size_nz;

  assign last       = step && (cnt == ONE);
  assign size_nz    = (size != '0);
  assign reload     = last && auto_reload;
  assign start_load = en_we && en_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (en_we) begin
        if (en_val) begin
          cnt    <= size;
          active <= size_nz;
        end else begin
          active <= 1'b0;
        end
      end else if (step) begin
        if (cnt == ONE) begin
          if (auto_reload) begin
            cnt    <= size;
            active <= size_nz;
          end else begin
            cnt    <= '0;
            active <= 1'b0;
          end
        end else begin
          cnt <= cnt - ONE;
        end
      end
    end
  end

  // R2: an active channel always has beats left
  p_active_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (cnt != '0));

  // R3: an idle channel with no enable write keeps its count and stays idle
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !en_we) |=> ($stable(cnt) && !active));

  // R7: count goes down by one on a middle beat
  p_cnt_dec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !en_we && cnt > ONE) |=> (cnt == $past(cnt) - ONE));

  // R8: done only follows a count of one
  p_done_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cnt) == ONE));

  // R9: no reload means the channel stops
  p_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last && !auto_reload && !en_we) |=> (!active && cnt == '0));

endmodule

// File: rtl/dma_addr_seq.sv
module dma_addr_seq #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_src_mode,
  input  logic              cfg_src_inc,
  input  logic              cfg_dst_mode,
  input  logic              cfg_dst_inc,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_fixed_en,
  input  logic              cfg_auto_reload,
  input  logic [ADDR_W-1:0] cfg_src_start,
  input  logic [ADDR_W-1:0] cfg_dst_start,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic [BLK_W-1:0]  cfg_blk_len,
  input  logic              en_we,
  input  logic              en_val,
  input  logic              beat_valid,
  output logic              beat_ready,
  output logic [ADDR_W-1:0] cur_src,
  output logic [ADDR_W-1:0] cur_dst,
  output logic [CNT_W-1:0]  cur_cnt,
  output logic              active,
  output logic              done
);

  logic beat_acc;
  logic start_load;
  logic reload;
  logic side_load;

  assign beat_ready = active;
  // an enable write owns the cycle; the beat waits
  assign beat_acc   = beat_valid && active && !en_we;
  assign side_load  = start_load || reload;

  dma_beat_count #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_we      (en_we),
    .en_val     (en_val),
    .step       (beat_acc),
    .auto_reload(cfg_auto_reload),
    .size       (cfg_size),
    .cnt        (cur_cnt),
    .active     (active),
    .done       (done),
    .start_load (start_load),
    .reload     (reload)
  );

  dma_addr_side #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (side_load),
    .step    (beat_acc),
    .mode    (cfg_src_mode),
    .inc     (cfg_src_inc),
    .fixed_en(cfg_fixed_en),
    .width   (cfg_width),
    .start   (cfg_src_start),
    .blk_len (cfg_blk_len),
    .addr    (cur_src)
  );

  dma_addr_side #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_dst (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (side_load),
    .step    (beat_acc),
    .mode    (cfg_dst_mode),
    .inc     (cfg_dst_inc),
    .fixed_en(cfg_fixed_en),
    .width   (cfg_width),
    .start   (cfg_dst_start),
    .blk_len (cfg_blk_len),
    .addr    (cur_dst)
  );

  // R3: beats offered while idle leave the addresses alone
  p_idle_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !en_we) |=> ($stable(cur_src) && $stable(cur_dst)));

  // R10: a reload restores the start addresses
  p_reload_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !en_we) |=> (cur_src == $past(cfg_src_start) && cur_dst == $past(cfg_dst_start)));

endmodule

// File: tb/dma_addr_seq_tb.sv
`timescale 1ns/1ps
module dma_addr_seq_tb;

  localparam int AW = 16;
  localparam int CW = 6;
  localparam int BW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_src_mode = 0, cfg_src_inc = 0, cfg_dst_mode = 0, cfg_dst_inc = 0;
  logic [1:0]    cfg_width = 0;
  logic          cfg_fixed_en = 0, cfg_auto_reload = 0;
  logic [AW-1:0] cfg_src_start = 0, cfg_dst_start = 0;
  logic [CW-1:0] cfg_size = 0;
  logic [BW-1:0] cfg_blk_len = 0;
  logic          en_we = 0, en_val = 0, beat_valid = 0;
  logic          beat_ready;
  logic [AW-1:0] cur_src, cur_dst;
  logic [CW-1:0] cur_cnt;
  logic          active, done;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  dma_addr_seq #(.ADDR_W(AW), .CNT_W(CW), .BLK_W(BW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_src_mode(cfg_src_mode), .cfg_src_inc(cfg_src_inc),
    .cfg_dst_mode(cfg_dst_mode), .cfg_dst_inc(cfg_dst_inc),
    .cfg_width(cfg_width), .cfg_fixed_en(cfg_fixed_en),
    .cfg_auto_reload(cfg_auto_reload),
    .cfg_src_start(cfg_src_start), .cfg_dst_start(cfg_dst_start),
    .cfg_size(cfg_size), .cfg_blk_len(cfg_blk_len),
    .en_we(en_we), .en_val(en_val), .beat_valid(beat_valid),
    .beat_ready(beat_ready), .cur_src(cur_src), .cur_dst(cur_dst),
    .cur_cnt(cur_cnt), .active(active), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // address after k beats since load, from the requirements
  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] st, input logic md,
      input logic up, input logic fx, input int w, input int bl, input int k);
    int bytes;
    int m;
    logic [AW-1:0] off;
    bytes = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    if (md && fx) return st;
    m = md ? (k % ((bl == 0) ? 1 : bl)) : k;
    off = AW'(m * bytes);
    return up ? st + off : st - off;
  endfunction

  task automatic enable_ch(input logic v);
    en_we = 1'b1; en_val = v;
    @(negedge clk);
    en_we = 1'b0; en_val = 1'b0;
  endtask

  task automatic run(input int w, input logic sm, input logic si, input logic fx,
                     input int bl, input logic ar, input int sz);
    logic dm;
    logic di;
    dm = ~sm; di = ~si;
    cfg_width = 2'(w); cfg_src_mode = sm; cfg_src_inc = si;
    cfg_dst_mode = dm; cfg_dst_inc = di; cfg_fixed_en = fx;
    cfg_auto_reload = ar; cfg_blk_len = BW'(bl); cfg_size = CW'(sz);
    cfg_src_start = 16'h1004; cfg_dst_start = 16'h0006;
    enable_ch(1'b1);
    chk("R2 active", 32'(active), 1);
    chk("R2 count", 32'(cur_cnt), 32'(sz));
    chk("R2 src", 32'(cur_src), 32'(cfg_src_start));
    chk("R3 ready", 32'(beat_ready), 1);
    for (int k = 1; k <= sz; k++) begin
      if (k % 3 == 0) begin
        beat_valid = 1'b0;
        @(negedge clk);
      end
      beat_valid = 1'b1;
      @(negedge clk);
      beat_valid = 1'b0;
      if (k < sz) begin
        chk("R7 count", 32'(cur_cnt), 32'(sz - k));
        chk("R4/R5/R6 src", 32'(cur_src), 32'(exp_addr(cfg_src_start, sm, si, fx, w, bl, k)));
        chk("R4/R5/R6 dst", 32'(cur_dst), 32'(exp_addr(cfg_dst_start, dm, di, fx, w, bl, k)));
        chk("R8 no done", 32'(done), 0);
      end else begin
        chk("R8 done", 32'(done), 1);
        if (ar) begin
          chk("R10 active", 32'(active), 1);
          chk("R10 count", 32'(cur_cnt), 32'(sz));
          chk("R10 src", 32'(cur_src), 32'(cfg_src_start));
          chk("R10 dst", 32'(cur_dst), 32'(cfg_dst_start));
        end else begin
          chk("R9 active", 32'(active), 0);
          chk("R9 count", 32'(cur_cnt), 0);
          chk("R9 src", 32'(cur_src), 32'(exp_addr(cfg_src_start, sm, si, fx, w, bl, k)));
          chk("R9 dst", 32'(cur_dst), 32'(exp_addr(cfg_dst_start, dm, di, fx, w, bl, k)));
        end
      end
    end
    @(negedge clk);
    chk("R8 one cycle", 32'(done), 0);
    if (!ar) begin
      beat_valid = 1'b1;
      repeat (2) @(negedge clk);
      beat_valid = 1'b0;
      chk("R3 idle count", 32'(cur_cnt), 0);
      chk("R3 idle src", 32'(cur_src), 32'(exp_addr(cfg_src_start, sm, si, fx, w, bl, sz)));
      chk("R3 idle dst", 32'(cur_dst), 32'(exp_addr(cfg_dst_start, dm, di, fx, w, bl, sz)));
      chk("R3 ready low", 32'(beat_ready), 0);
    end else begin
      enable_ch(1'b0);
      chk("R11 off", 32'(active), 0);
      chk("R11 count kept", 32'(cur_cnt), 32'(sz));
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    chk("R1 active", 32'(active), 0);
    chk("R1 done", 32'(done), 0);
    chk("R1 count", 32'(cur_cnt), 0);
    chk("R1 src", 32'(cur_src), 0);
    chk("R1 dst", 32'(cur_dst), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: size zero leaves the channel idle
    cfg_size = '0; cfg_src_start = 16'h0040;
    enable_ch(1'b1);
    chk("R2 size zero idle", 32'(active), 0);
    chk("R2 size zero src", 32'(cur_src), 32'h40);

    idx = 0;
    for (int w = 0; w < 4; w++)
      for (int sm = 0; sm < 2; sm++)
        for (int si = 0; si < 2; si++)
          for (int fx = 0; fx < 2; fx++)
            for (int bl = 0; bl < 5; bl++) begin
              run(w, 1'(sm), 1'(si), 1'(fx), bl, 1'(idx % 2), 5 + (bl % 3));
              idx++;
            end

    // R11: enable write beats a same-cycle beat; disable mid-run holds state
    cfg_width = 2'd1; cfg_src_mode = 1'b0; cfg_src_inc = 1'b1;
    cfg_dst_mode = 1'b0; cfg_dst_inc = 1'b1; cfg_fixed_en = 1'b0;
    cfg_auto_reload = 1'b0; cfg_size = 6'd9;
    cfg_src_start = 16'h0100; cfg_dst_start = 16'h0200;
    enable_ch(1'b1);
    beat_valid = 1'b1;
    repeat (2) @(negedge clk);
    en_we = 1'b1; en_val = 1'b1;
    @(negedge clk);
    en_we = 1'b0; en_val = 1'b0; beat_valid = 1'b0;
    chk("R11 enable wins count", 32'(cur_cnt), 9);
    chk("R11 enable wins src", 32'(cur_src), 32'h100);
    beat_valid = 1'b1;
    repeat (2) @(negedge clk);
    en_we = 1'b1; en_val = 1'b0;
    @(negedge clk);
    en_we = 1'b0; beat_valid = 1'b0;
    chk("R11 disable active", 32'(active), 0);
    chk("R11 disable count", 32'(cur_cnt), 7);
    chk("R11 disable src", 32'(cur_src), 32'h104);
    chk("R11 disable dst", 32'(cur_dst), 32'h204);

    finish_run();
  end

endmodule